// File: doc/BRIEF.md
# PCI Master Termination Controller

This block is the initiator-side sequencer for a PCI-style multiplexed bus. A local client starts one request. The request carries a start address, a direction, a write word and a beat count. The block then asks the arbiter for the bus, drives the address phase and walks through the data phases. It watches the target's device-select, ready and stop lines and decides how each bus attempt ends. Every attempt finishes with a one-cycle done pulse and a three-bit outcome code.

When a target stops the burst, the block classifies the stop. It keeps its bus request negated for the required back-off. For a retry it reissues the whole request on its own. For a disconnect it reissues the remainder, starting from the first word that was not moved. The local client sees the block busy until the request has either completed or been aborted. A target that never claims the cycle leads to a master-abort, and a read that is master-aborted hands all-ones to the client. A target that aborts the cycle sets a sticky status flag, which software clears with a write-one-to-clear pulse.

Top module: `pci_master_term`

## Requirements
- R1: While reset is high and just after it, `bus_want_n`, `bus_cyc_n` and `bus_mrdy_n` are high, and `loc_busy`, `loc_done`, `loc_rvalid` and `sta_tabort` are low.
- R2: A `loc_start` pulse seen while idle makes `loc_busy` high and `bus_want_n` low in the next clock. Once `bus_grant_n` is sampled low, the next clock is the address phase: `bus_cyc_n` is low, `bus_mrdy_n` is high, `bus_ad_out` carries the address and `bus_wr` carries the direction (1 = write).
- R3: A beat moves on each rising edge where `bus_mrdy_n`, `tgt_sel_n` and `tgt_rdy_n` are all low. `bus_cyc_n` is high only during the final data clock. After the final beat, both `bus_cyc_n` and `bus_mrdy_n` are high, and the outcome code is 0 (complete). On writes, every beat drives the write word on `bus_ad_out`.
- R4: Each read beat produces a `loc_rvalid` pulse one clock later, with `loc_rdata` equal to the `bus_ad_in` value of that beat.
- R5: If `tgt_sel_n` stays high for four data clocks, `bus_mrdy_n` is low for exactly those four clocks, and the fifth clock after the address phase starts is idle. The outcome is 1 (master-abort). A select that first appears in the fourth data clock is accepted.
- R6: A master-aborted read gives a `loc_rvalid` pulse with `loc_rdata` all-ones in the done cycle. A master-abort, read or write, is never reissued.
- R7: A beat that coincides with a stop still moves when select and ready are both low. A stop with ready high moves nothing. A stop on the final beat with ready low counts as a complete outcome.
- R8: A stop with `tgt_sel_n` high is a target-abort, outcome 4. It sets `sta_tabort` and is never reissued.
- R9: `sta_tabort` stays set until a `sta_clr` pulse clears it. A new abort in the same clock wins over the clear.
- R10: A stop with select low and no beat moved in the attempt is a retry, outcome 3. The same address and the same beat count are reissued.
- R11: A stop after at least one beat is a disconnect, outcome 2. `loc_resume_addr` holds the address of the first word not moved (start + 4 × beats moved), and the reissue starts there with the remaining beats.
- R12: After any stop, `bus_want_n` is high for exactly two clocks. The first is the idle clock, with `bus_cyc_n` and `bus_mrdy_n` high. When a reissue follows, `bus_want_n` goes low in the third clock.
- R13: `loc_done` is a single-clock pulse for each bus attempt. `loc_busy` stays high across reissues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_start | input | 1 | Start a request (taken when idle) |
| loc_addr | input | AW | Start byte address |
| loc_write | input | 1 | 1 = write, 0 = read |
| loc_wdata | input | DW | Word written on every write beat |
| loc_len | input | LW | Beat count, at least 1 |
| loc_busy | output | 1 | Request in progress |
| loc_done | output | 1 | One-clock pulse at the end of each bus attempt |
| loc_outcome | output | 3 | 0 complete, 1 master-abort, 2 disconnect, 3 retry, 4 target-abort |
| loc_rdata | output | DW | Read word |
| loc_rvalid | output | 1 | Read word valid |
| loc_resume_addr | output | AW | Address of next untransferred word |
| sta_tabort | output | 1 | Sticky received-target-abort flag |
| sta_clr | input | 1 | Write-one-to-clear for the flag |
| bus_want_n | output | 1 | Bus request to the arbiter, low active |
| bus_grant_n | input | 1 | Bus grant, low active |
| bus_cyc_n | output | 1 | Cycle framing, low active |
| bus_mrdy_n | output | 1 | Initiator ready, low active |
| bus_ad_out | output | DW | Address/data driven |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_wr | output | 1 | Command direction, 1 = write |
| bus_ad_in | input | DW | Address/data received |
| tgt_sel_n | input | 1 | Target claims the cycle, low active |
| tgt_rdy_n | input | 1 | Target ready, low active |
| tgt_halt_n | input | 1 | Target requests stop, low active |

## Verification
A wrong beat count or a wrong address register shows up on the bus quickly. The framing line rises one clock early or late, or the reissued address phase carries the wrong address. Either shows within the same attempt or the very next one. A select timer that counts wrong moves the master-abort off the fifth clock after the address phase, so the count of initiator-ready clocks is off by one at once. A stop that is misclassified changes the outcome code in the done cycle. It also changes what follows: whether a second address phase appears about three clocks later, and at which address. The back-off is measured directly as the length of the high run on the request line.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    typedef enum logic [2:0] {
        TERM_OK     = 3'd0,
        TERM_MABORT = 3'd1,
        TERM_DISC   = 3'd2,
        TERM_RETRY  = 3'd3,
        TERM_TABORT = 3'd4
    } term_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA,
        ST_TURN,
        ST_BACK
    } seq_e;

    // Target response sampled in one data clock (active high here)
    typedef struct packed {
        logic sel;
        logic rdy;
        logic halt;
    } tgt_resp_t;

    // Decision for the current data clock
    typedef struct packed {
        logic  done;
        logic  by_stop;
        logic  moved;
        term_e code;
    } verdict_t;

    function automatic logic needs_reissue(term_e c);
        return (c == TERM_RETRY) || (c == TERM_DISC);
    endfunction

endpackage

// File: rtl/pmt_sel_timer.sv
module pmt_sel_timer #(
    parameter int SEL_WAIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic active,
    input  logic sel,
    output logic timeout
);
    localparam int CW = $clog2(SEL_WAIT + 1);

    logic          seen_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else if (arm) begin
            seen_q <= 1'b0;
            cnt_q  <= '0;
        end else if (active) begin
            if (sel)
                seen_q <= 1'b1;
            else if (!seen_q)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign timeout = active && !seen_q && !sel && (cnt_q == CW'(SEL_WAIT - 1));

    // R5: the wait count never passes its limit while data clocks run
    assert_wait_bound_R5: assert property (@(posedge clk) disable iff (rst)
        active |-> (int'(cnt_q) < SEL_WAIT));

endmodule

// File: rtl/pmt_classify.sv
module pmt_classify
    import pmt_pkg::*;
(
    input  logic      active,
    input  tgt_resp_t resp,
    input  logic      last_beat,
    input  logic      any_prior,
    input  logic      timeout,
    output verdict_t  verdict
);
    always_comb begin
        verdict      = '0;
        verdict.code = TERM_OK;
        if (active) begin
            verdict.moved = resp.sel & resp.rdy;
            if (resp.halt) begin
                verdict.done    = 1'b1;
                verdict.by_stop = 1'b1;
                if (!resp.sel)
                    verdict.code = TERM_TABORT;
                else if (verdict.moved && last_beat)
                    verdict.code = TERM_OK;
                else if (verdict.moved || any_prior)
                    verdict.code = TERM_DISC;
                else
                    verdict.code = TERM_RETRY;
            end else if (verdict.moved && last_beat) begin
                verdict.done = 1'b1;
                verdict.code = TERM_OK;
            end else if (timeout) begin
                verdict.done = 1'b1;
                verdict.code = TERM_MABORT;
            end
        end
    end
endmodule

// File: rtl/pci_master_term.sv
module pci_master_term
    import pmt_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int LW       = 8,
    parameter int SEL_WAIT = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          loc_start,
    input  logic [AW-1:0] loc_addr,
    input  logic          loc_write,
    input  logic [DW-1:0] loc_wdata,
    input  logic [LW-1:0] loc_len,
    output logic          loc_busy,
    output logic          loc_done,
    output logic [2:0]    loc_outcome,
    output logic [DW-1:0] loc_rdata,
    output logic          loc_rvalid,
    output logic [AW-1:0] loc_resume_addr,
    output logic          sta_tabort,
    input  logic          sta_clr,
    output logic          bus_want_n,
    input  logic          bus_grant_n,
    output logic          bus_cyc_n,
    output logic          bus_mrdy_n,
    output logic [DW-1:0] bus_ad_out,
    output logic          bus_ad_oe,
    output logic          bus_wr,
    input  logic [DW-1:0] bus_ad_in,
    input  logic          tgt_sel_n,
    input  logic          tgt_rdy_n,
    input  logic          tgt_halt_n
);
    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    seq_e          state_q;
    logic [AW-1:0] addr_q;
    logic [LW-1:0] rem_q;
    logic [DW-1:0] wdata_q;
    logic          wr_q;
    logic          moved_any_q;
    logic          stop_end_q;
    logic          done_q;
    term_e         code_q;
    logic [DW-1:0] rdata_q;
    logic          rvalid_q;
    logic          sta_q;

    logic      in_data;
    logic      last_beat;
    logic      timeout;
    logic      sta_set;
    tgt_resp_t resp;
    verdict_t  verdict;

    assign in_data   = (state_q == ST_DATA);
    assign last_beat = (rem_q == LW'(1));
    assign resp      = '{sel: !tgt_sel_n, rdy: !tgt_rdy_n, halt: !tgt_halt_n};

    pmt_sel_timer #(.SEL_WAIT(SEL_WAIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .arm     (state_q == ST_ADDR),
        .active  (in_data),
        .sel     (resp.sel),
        .timeout (timeout)
    );

    pmt_classify u_cls (
        .active    (in_data),
        .resp      (resp),
        .last_beat (last_beat),
        .any_prior (moved_any_q),
        .timeout   (timeout),
        .verdict   (verdict)
    );

    assign sta_set = verdict.done && (verdict.code == TERM_TABORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            rem_q       <= '0;
            wdata_q     <= '0;
            wr_q        <= 1'b0;
            moved_any_q <= 1'b0;
            stop_end_q  <= 1'b0;
            done_q      <= 1'b0;
            code_q      <= TERM_OK;
            rdata_q     <= '0;
            rvalid_q    <= 1'b0;
            sta_q       <= 1'b0;
        end else begin
            done_q   <= 1'b0;
            rvalid_q <= 1'b0;
            if (sta_set)
                sta_q <= 1'b1;
            else if (sta_clr)
                sta_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (loc_start) begin
                    addr_q  <= loc_addr;
                    wr_q    <= loc_write;
                    wdata_q <= loc_wdata;
                    rem_q   <= loc_len;
                    state_q <= ST_REQ;
                end
                ST_REQ: if (!bus_grant_n) state_q <= ST_ADDR;
                ST_ADDR: begin
                    moved_any_q <= 1'b0;
                    state_q     <= ST_DATA;
                end
                ST_DATA: begin
                    if (verdict.moved) begin
                        addr_q      <= addr_q + STEP;
                        rem_q       <= rem_q - 1'b1;
                        moved_any_q <= 1'b1;
                        if (!wr_q) begin
                            rdata_q  <= bus_ad_in;
                            rvalid_q <= 1'b1;
                        end
                    end
                    if (verdict.done) begin
                        state_q    <= ST_TURN;
                        done_q     <= 1'b1;
                        code_q     <= verdict.code;
                        stop_end_q <= verdict.by_stop;
                        if (verdict.code == TERM_MABORT && !wr_q) begin
                            rdata_q  <= '1;
                            rvalid_q <= 1'b1;
                        end
                    end
                end
                ST_TURN: state_q <= stop_end_q ? ST_BACK : ST_IDLE;
                ST_BACK: state_q <= needs_reissue(code_q) ? ST_REQ : ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign loc_busy        = (state_q != ST_IDLE);
    assign loc_done        = done_q;
    assign loc_outcome     = code_q;
    assign loc_rdata       = rdata_q;
    assign loc_rvalid      = rvalid_q;
    assign loc_resume_addr = addr_q;
    assign sta_tabort      = sta_q;

    assign bus_want_n = !(state_q == ST_REQ || state_q == ST_ADDR || in_data);
    assign bus_cyc_n  = !(state_q == ST_ADDR || (in_data && !last_beat));
    assign bus_mrdy_n = !in_data;
    assign bus_ad_out = (state_q == ST_ADDR) ? DW'(addr_q) : wdata_q;
    assign bus_ad_oe  = (state_q == ST_ADDR) || (in_data && wr_q);
    assign bus_wr     = wr_q;

    // R12: request stays negated in the two clocks after a sampled stop
    assert_backoff_first_R12: assert property (@(posedge clk) disable iff (rst)
        (!bus_mrdy_n && !tgt_halt_n) |=> bus_want_n);
    assert_backoff_second_R12: assert property (@(posedge clk) disable iff (rst)
        $past(!bus_mrdy_n && !tgt_halt_n, 2) |-> bus_want_n);
    // R3: after the final beat the bus is released at once
    assert_release_R3: assert property (@(posedge clk) disable iff (rst)
        (!bus_mrdy_n && bus_cyc_n && !tgt_sel_n && !tgt_rdy_n) |=> (bus_mrdy_n && bus_cyc_n));
    // R6: master-aborted read hands back all-ones
    assert_abort_ones_R6: assert property (@(posedge clk) disable iff (rst)
        (done_q && code_q == TERM_MABORT && !wr_q) |-> (rvalid_q && rdata_q == '1));
    // R8: target-abort outcome always raises the flag
    assert_tabort_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (done_q && code_q == TERM_TABORT) |-> sta_q);
    // R9: flag holds without a clear
    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (sta_q && !sta_clr) |=> sta_q);
    // R13: done is a single-clock pulse
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: tb/test_pci_master_term.sv
module test_pci_master_term;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        loc_start = 1'b0;
    logic [31:0] loc_addr = '0;
    logic        loc_write = 1'b0;
    logic [31:0] loc_wdata = '0;
    logic [7:0]  loc_len = '0;
    logic        loc_busy, loc_done, loc_rvalid, sta_tabort;
    logic [2:0]  loc_outcome;
    logic [31:0] loc_rdata, loc_resume_addr, bus_ad_out;
    logic        sta_clr = 1'b0;
    logic        bus_want_n, bus_cyc_n, bus_mrdy_n, bus_ad_oe, bus_wr;
    logic        bus_grant_n = 1'b0;
    logic [31:0] bus_ad_in = '0;
    logic        tgt_sel_n = 1'b1, tgt_rdy_n = 1'b1, tgt_halt_n = 1'b1;

    always #4 clk = ~clk;

    pci_master_term i_pci_master_term (
        .clk(clk), .rst(rst),
        .loc_start(loc_start), .loc_addr(loc_addr), .loc_write(loc_write),
        .loc_wdata(loc_wdata), .loc_len(loc_len), .loc_busy(loc_busy),
        .loc_done(loc_done), .loc_outcome(loc_outcome), .loc_rdata(loc_rdata),
        .loc_rvalid(loc_rvalid), .loc_resume_addr(loc_resume_addr),
        .sta_tabort(sta_tabort), .sta_clr(sta_clr),
        .bus_want_n(bus_want_n), .bus_grant_n(bus_grant_n), .bus_cyc_n(bus_cyc_n),
        .bus_mrdy_n(bus_mrdy_n), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_wr(bus_wr), .bus_ad_in(bus_ad_in),
        .tgt_sel_n(tgt_sel_n), .tgt_rdy_n(tgt_rdy_n), .tgt_halt_n(tgt_halt_n)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // target model configuration
    int cfg_sel_at = 1, cfg_rdy_from = 1, cfg_stop_at = 0, cfg_stop_tries = 0;
    logic cfg_stop_sel = 1'b1, cfg_stop_rdy = 1'b0;

    // monitor logs
    int dclk = 0, attempt = 0, ndone = 0, nrd = 0, nbeat = 0, ncyc = 0, nmrdy = 0;
    int run = 0, last_run = 0;
    logic [2:0]  out_log [16];
    logic [31:0] res_log [16];
    logic [31:0] rd_log  [16];
    logic [31:0] addr_log[16];
    logic        wr_log  [16];
    logic        frm_log [16];
    logic [31:0] wd_log  [16];

    always @(negedge clk) begin
        logic sel, rdy, stop_now;
        if (!rst) begin
            if (loc_done) begin
                out_log[ndone & 15] = loc_outcome;
                res_log[ndone & 15] = loc_resume_addr;
                ndone++;
            end
            if (loc_rvalid) begin rd_log[nrd & 15] = loc_rdata; nrd++; end
            if (!bus_cyc_n) ncyc++;
            if (!bus_mrdy_n) nmrdy++;
            if (bus_want_n) run++;
            else begin if (run > 0) last_run = run; run = 0; end
            if (!bus_cyc_n && bus_mrdy_n) begin
                addr_log[attempt & 15] = bus_ad_out;
                wr_log[attempt & 15]   = bus_wr;
                attempt++;
            end
        end
        dclk = bus_mrdy_n ? 0 : dclk + 1;
        stop_now = (cfg_stop_at != 0) && (dclk == cfg_stop_at) && (attempt <= cfg_stop_tries);
        sel = (dclk > 0) && (cfg_sel_at != 0) && (dclk >= cfg_sel_at);
        if (stop_now) sel = cfg_stop_sel;
        rdy = sel && (dclk >= cfg_rdy_from);
        if (stop_now) rdy = sel && cfg_stop_rdy;
        tgt_sel_n  = !sel;
        tgt_rdy_n  = !rdy;
        tgt_halt_n = !stop_now;
        bus_ad_in  = 32'hA000_0000 + 32'(dclk) + 32'(attempt << 8);
        if (dclk > 0 && sel && rdy) begin
            frm_log[nbeat & 15] = bus_cyc_n;
            wd_log[nbeat & 15]  = bus_ad_out;
            nbeat++;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        attempt = 0; ndone = 0; nrd = 0; nbeat = 0; ncyc = 0; nmrdy = 0;
        cfg_sel_at = 1; cfg_rdy_from = 1; cfg_stop_at = 0; cfg_stop_tries = 0;
        cfg_stop_sel = 1'b1; cfg_stop_rdy = 1'b0;
    endtask

    task automatic launch(input logic [31:0] a, input logic w, input logic [31:0] d,
                          input int len);
        @(negedge clk);
        loc_start = 1'b1; loc_addr = a; loc_write = w; loc_wdata = d; loc_len = 8'(len);
        @(negedge clk);
        loc_start = 1'b0;
        chk(!bus_want_n && loc_busy, "R2", "request raised after start",
            {bus_want_n, loc_busy}, 2'b01);
        while (loc_busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(bus_want_n && bus_cyc_n && bus_mrdy_n && !loc_busy && !loc_done &&
            !loc_rvalid && !sta_tabort, "R1", "idle after reset",
            {bus_want_n, bus_cyc_n, bus_mrdy_n, loc_busy, loc_done, loc_rvalid, sta_tabort},
            7'b1110000);
    endtask

    task automatic t_write_burst();
        clear_logs();
        launch(32'h1000, 1'b1, 32'hDEAD_BEEF, 4);
        chk(ndone == 1 && out_log[0] == 3'd0, "R3", "outcome complete", out_log[0], 0);
        chk(addr_log[0] == 32'h1000 && wr_log[0], "R2", "address phase", addr_log[0], 32'h1000);
        chk(nbeat == 4, "R3", "beats moved", nbeat, 4);
        chk(!frm_log[0] && !frm_log[1] && !frm_log[2] && frm_log[3], "R3",
            "framing on beats", {frm_log[0], frm_log[1], frm_log[2], frm_log[3]}, 4'b0001);
        chk(wd_log[0] == 32'hDEAD_BEEF && wd_log[3] == 32'hDEAD_BEEF, "R3",
            "write word", wd_log[3], 32'hDEAD_BEEF);
        chk(nrd == 0 && attempt == 1, "R13", "single attempt", attempt, 1);
    endtask

    task automatic t_read_burst();
        clear_logs();
        cfg_sel_at = 2; cfg_rdy_from = 3;
        launch(32'h2000, 1'b0, 32'h0, 2);
        chk(nrd == 2, "R4", "read pulses", nrd, 2);
        chk(rd_log[0] == 32'hA000_0103 && rd_log[1] == 32'hA000_0104, "R4",
            "read words", rd_log[1], 32'hA000_0104);
        chk(out_log[0] == 3'd0 && wr_log[0] == 1'b0, "R3", "read outcome", out_log[0], 0);
    endtask

    task automatic t_mabort_read();
        clear_logs();
        cfg_sel_at = 0;
        launch(32'h2100, 1'b0, 32'h0, 3);
        chk(nmrdy == 4 && ncyc == 5, "R5", "timeout clocks", nmrdy, 4);
        chk(ndone == 1 && out_log[0] == 3'd1, "R5", "master-abort code", out_log[0], 1);
        chk(nrd == 1 && rd_log[0] == 32'hFFFF_FFFF, "R6", "all-ones read", rd_log[0],
            32'hFFFF_FFFF);
        chk(attempt == 1 && !sta_tabort, "R6", "no reissue", attempt, 1);
    endtask

    task automatic t_mabort_write();
        clear_logs();
        cfg_sel_at = 0;
        launch(32'h2200, 1'b1, 32'h1234_5678, 1);
        chk(out_log[0] == 3'd1 && nmrdy == 4, "R5", "write master-abort", out_log[0], 1);
        chk(attempt == 1 && nrd == 0 && ndone == 1, "R6", "write dropped", attempt, 1);
    endtask

    task automatic t_late_sel();
        clear_logs();
        cfg_sel_at = 4; cfg_rdy_from = 4;
        launch(32'h2300, 1'b0, 32'h0, 1);
        chk(out_log[0] == 3'd0 && nbeat == 1, "R5", "select in fourth clock", out_log[0], 0);
        chk(nrd == 1 && rd_log[0] == 32'hA000_0104, "R4", "late read word", rd_log[0],
            32'hA000_0104);
    endtask

    task automatic t_tabort();
        clear_logs();
        cfg_stop_at = 2; cfg_stop_sel = 1'b0; cfg_stop_rdy = 1'b0; cfg_stop_tries = 9;
        launch(32'h5000, 1'b1, 32'h0, 4);
        chk(ndone == 1 && out_log[0] == 3'd4, "R8", "target-abort code", out_log[0], 4);
        chk(attempt == 1 && sta_tabort, "R8", "flag set, no reissue", attempt, 1);
        repeat (3) @(negedge clk);
        chk(sta_tabort, "R9", "flag sticky", sta_tabort, 1);
        sta_clr = 1'b1;
        @(negedge clk);
        sta_clr = 1'b0;
        chk(!sta_tabort, "R9", "flag cleared", sta_tabort, 0);
    endtask

    task automatic t_retry();
        clear_logs();
        cfg_stop_at = 1; cfg_stop_sel = 1'b1; cfg_stop_rdy = 1'b0; cfg_stop_tries = 1;
        launch(32'h3000, 1'b0, 32'h0, 2);
        chk(ndone == 2 && out_log[0] == 3'd3 && out_log[1] == 3'd0, "R10",
            "retry then complete", {out_log[0], out_log[1]}, 6'o30);
        chk(attempt == 2 && addr_log[1] == 32'h3000, "R10", "reissue address",
            addr_log[1], 32'h3000);
        chk(nrd == 2 && rd_log[1] == 32'hA000_0202, "R10", "reissued reads", rd_log[1],
            32'hA000_0202);
        chk(last_run == 2, "R12", "back-off length", last_run, 2);
    endtask

    task automatic t_disc(input logic rdy_on_stop);
        logic [31:0] exp_res;
        clear_logs();
        cfg_stop_at = 3; cfg_stop_sel = 1'b1; cfg_stop_rdy = rdy_on_stop; cfg_stop_tries = 1;
        exp_res = rdy_on_stop ? 32'h400C : 32'h4008;
        launch(32'h4000, 1'b1, 32'h0, 4);
        chk(out_log[0] == 3'd2 && out_log[1] == 3'd0, "R11", "disconnect then complete",
            {out_log[0], out_log[1]}, 6'o20);
        chk(res_log[0] == exp_res, "R11", "resume address", res_log[0], exp_res);
        chk(addr_log[1] == exp_res, "R11", "reissue address", addr_log[1], exp_res);
        chk(nbeat == 4, "R7", "total beats with stop", nbeat, 4);
        chk(last_run == 2, "R12", "back-off length", last_run, 2);
    endtask

    task automatic t_stop_last();
        clear_logs();
        cfg_stop_at = 2; cfg_stop_sel = 1'b1; cfg_stop_rdy = 1'b1; cfg_stop_tries = 9;
        launch(32'h6000, 1'b1, 32'h0, 2);
        chk(ndone == 1 && out_log[0] == 3'd0 && nbeat == 2, "R7", "stop on last beat",
            out_log[0], 0);
        chk(attempt == 1 && bus_want_n, "R12", "no re-request", attempt, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_burst();
        t_read_burst();
        t_mabort_read();
        t_mabort_write();
        t_late_sel();
        t_tabort();
        t_retry();
        t_disc(1'b1);
        t_disc(1'b0);
        t_stop_last();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule